// File: doc/BRIEF.md
# Single-Wire Debug Host Bit Engine

This block is the host-side bit timer for an open-drain, single-wire debug link. It moves one bit per request. Every bit, whether it is sent or received, opens with the host pulling the shared line low. A clock matched to the target's clock sets every time within the bit.

To send a 1, the host pulls the line low for a short time. It then drives the line high for one cycle, which gives a sharp rising edge, and lets go. To send a 0, the host holds the line low for most of the bit and ends with the same one-cycle high pulse. To receive, the host pulls the line low for only two cycles and then releases it, so that the target can drive the line. The host reads the level near cycle 10 through a two-flop synchroniser, and the capture point is moved later to cover the synchroniser's delay.

Each bit takes a fixed slot of `SLOT_CYC` cycles. The slot length, the low times, the sample point and the synchroniser depth are all parameters. A controller higher up feeds the engine one bit at a time. It may present the next request during the last cycle of a slot, so that bits follow each other with no gap.

Top module: `swd_host_bit`

## Requirements
- R1: After reset, `drv_en`, `drv_hi`, `done` and `rx_bit` are 0 and `req_ready` is 1.
- R2: A request is accepted at a clock edge where `req_valid` and `req_ready` are both 1. The slot starts in the next cycle as slot cycle 0. `req_ready` is 1 when the engine is idle and during slot cycle 15, and 0 in every other slot cycle.
- R3: For a write of 1 (`req_rd`=0, `req_wbit`=1), the line is driven low in slot cycles 0 to 3 (`drv_en`=1, `drv_hi`=0). It is driven high in cycle 4 (`drv_en`=1, `drv_hi`=1) and released (`drv_en`=0) in cycles 5 to 15. The line is never driven low at or after cycle 8.
- R4: For a write of 0 (`req_rd`=0, `req_wbit`=0), the line is driven low in slot cycles 0 to 12, driven high in cycle 13, and released in cycles 14 and 15.
- R5: For a read (`req_rd`=1), the line is driven low in slot cycles 0 and 1 and released from cycle 2 to the end of the slot.
- R6: On a read, `rx_bit` takes the level that `line_in` had during slot cycle 10. The new value is visible from slot cycle 13. It holds until the next read capture, and slots that are writes leave it unchanged.
- R7: `done` is 1 for exactly one cycle per bit, in slot cycle 15. It is 0 at all other times.
- R8: A request presented during slot cycles 0 to 14 is ignored. The running slot keeps its pattern, and no slot follows unless a request is present in cycle 15 or later.
- R9: A driven-high cycle always comes straight after a driven-low cycle and lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock matched to the target clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bit request present |
| req_rd | input | 1 | 1 = receive a bit, 0 = send a bit |
| req_wbit | input | 1 | Bit value to send |
| req_ready | output | 1 | A request is taken at this edge if valid |
| line_in | input | 1 | Level sensed on the debug line |
| drv_en | output | 1 | 1 = host drives the line |
| drv_hi | output | 1 | Driven level when `drv_en` is 1 (1 = high) |
| rx_bit | output | 1 | Last received bit |
| done | output | 1 | One-cycle pulse in the last slot cycle |

## Verification
A slot counter that is off by one moves every edge of the drive pattern. It also moves the `done` pulse and the `req_ready` window by one cycle within the same slot, so the first bit after the error shows it. A wrong synchroniser depth or capture cycle makes `rx_bit` take the line level of a cycle next to cycle 10. It also moves the cycle in which the new value appears, so a target pattern that is low only in cycle 10 exposes the error on the first read. A wrongly latched direction or data bit shows up at once as the wrong drive pattern, or as a change to `rx_bit` after a slot that was a write.

// File: rtl/swd_host_pkg.sv
package swd_host_pkg;

  typedef struct packed {
    logic rd;
    logic wbit;
  } bit_req_t;

  // Number of cycles the host holds the line low at the start of a slot.
  function automatic int low_cycles(logic rd, logic wbit,
                                    int one_low, int zero_low, int rd_low);
    if (rd)        return rd_low;
    else if (wbit) return one_low;
    else           return zero_low;
  endfunction

  // Slot cycle at which the sampler register captures, given the wanted
  // line sample cycle and the synchroniser depth.
  function automatic int capture_cycle(int sample_at, int sync_stages);
    return sample_at + sync_stages;
  endfunction

endpackage

// File: rtl/swd_slot_timer.sv
module swd_slot_timer
  import swd_host_pkg::*;
#(
  parameter int SLOT_CYC = 16,
  localparam int CNT_W = $clog2(SLOT_CYC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  bit_req_t         req_in,
  output logic             ready,
  output logic             active,
  output logic             last,
  output logic [CNT_W-1:0] cnt,
  output bit_req_t         cur
);

  logic accept;

  assign last   = active && (cnt == CNT_W'(SLOT_CYC - 1));
  assign ready  = !active || last;
  assign accept = req_valid && ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      cur    <= '0;
    end else if (accept) begin
      active <= 1'b1;
      cnt    <= '0;
      cur    <= req_in;
    end else if (active) begin
      if (last) active <= 1'b0;
      else      cnt    <= cnt + 1'b1;
    end
  end

  AST_SLOT_START: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (active && cnt == '0)) else $error("slot start"); // R2

  AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !last && req_valid) |=> (active && cnt == $past(cnt) + 1'b1 && cur == $past(cur)))
    else $error("busy request"); // R8

endmodule

// File: rtl/swd_line_driver.sv
module swd_line_driver
  import swd_host_pkg::*;
#(
  parameter int SLOT_CYC = 16,
  parameter int ONE_LOW  = 4,
  parameter int ZERO_LOW = 13,
  parameter int RD_LOW   = 2,
  localparam int CNT_W = $clog2(SLOT_CYC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [CNT_W-1:0] cnt,
  input  bit_req_t         cur,
  output logic             drv_en,
  output logic             drv_hi
);

  logic [CNT_W:0] low_len;
  logic           in_low;
  logic           in_pulse;

  always_comb begin
    low_len  = (CNT_W + 1)'(low_cycles(cur.rd, cur.wbit, ONE_LOW, ZERO_LOW, RD_LOW));
    in_low   = active && ({1'b0, cnt} < low_len);
    in_pulse = active && !cur.rd && ({1'b0, cnt} == low_len);
  end

  assign drv_en = in_low || in_pulse;
  assign drv_hi = in_pulse;

  AST_HI_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en && drv_hi) |-> $past(drv_en && !drv_hi)) else $error("hi w/o low"); // R9

  AST_HI_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en && drv_hi) |=> !(drv_en && drv_hi)) else $error("long hi"); // R9

  AST_ONE_DEADLINE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !cur.rd && cur.wbit && cnt >= CNT_W'(8)) |-> !drv_en) else $error("one late"); // R3

  AST_RD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cur.rd && cnt >= CNT_W'(7)) |-> !drv_en) else $error("rd drive"); // R5

endmodule

// File: rtl/swd_sampler.sv
module swd_sampler
  import swd_host_pkg::*;
#(
  parameter int SLOT_CYC    = 16,
  parameter int SAMPLE_AT   = 10,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W  = $clog2(SLOT_CYC),
  localparam int CAP_AT = capture_cycle(SAMPLE_AT, SYNC_STAGES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_in,
  input  logic             active,
  input  logic [CNT_W-1:0] cnt,
  input  bit_req_t         cur,
  output logic             rx_bit
);

  logic [SYNC_STAGES:0] sq;
  logic                 cap;

  assign sq[0] = line_in;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rst_n) sq[i+1] <= 1'b1;
      else        sq[i+1] <= sq[i];
    end
  end

  assign cap = active && cur.rd && (cnt == CNT_W'(CAP_AT));

  always_ff @(posedge clk) begin
    if (!rst_n)   rx_bit <= 1'b0;
    else if (cap) rx_bit <= sq[SYNC_STAGES];
  end

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cap) |-> $stable(rx_bit)) else $error("rx moved"); // R6

endmodule

// File: rtl/swd_host_bit.sv
module swd_host_bit
  import swd_host_pkg::*;
#(
  parameter int SLOT_CYC    = 16,
  parameter int ONE_LOW     = 4,
  parameter int ZERO_LOW    = 13,
  parameter int RD_LOW      = 2,
  parameter int SAMPLE_AT   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_rd,
  input  logic req_wbit,
  output logic req_ready,
  input  logic line_in,
  output logic drv_en,
  output logic drv_hi,
  output logic rx_bit,
  output logic done
);

  localparam int CNT_W = $clog2(SLOT_CYC);

  initial begin
    assert (ONE_LOW + 1 <= 8) else $error("one pulse too late");
    assert (RD_LOW >= 2 && RD_LOW < 7) else $error("read release window");
    assert (ZERO_LOW + 1 < SLOT_CYC) else $error("zero does not fit");
    assert (SYNC_STAGES >= 1) else $error("sync depth");
    assert (capture_cycle(SAMPLE_AT, SYNC_STAGES) < SLOT_CYC - 1) else $error("capture late");
  end

  bit_req_t         req_in;
  bit_req_t         cur;
  logic             active;
  logic             last;
  logic [CNT_W-1:0] cnt;

  assign req_in = '{rd: req_rd, wbit: req_wbit};

  swd_slot_timer #(.SLOT_CYC(SLOT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_in(req_in),
    .ready(req_ready), .active(active), .last(last), .cnt(cnt), .cur(cur)
  );

  swd_line_driver #(.SLOT_CYC(SLOT_CYC), .ONE_LOW(ONE_LOW), .ZERO_LOW(ZERO_LOW),
                    .RD_LOW(RD_LOW)) u_drv (
    .clk(clk), .rst_n(rst_n), .active(active), .cnt(cnt), .cur(cur),
    .drv_en(drv_en), .drv_hi(drv_hi)
  );

  swd_sampler #(.SLOT_CYC(SLOT_CYC), .SAMPLE_AT(SAMPLE_AT),
                .SYNC_STAGES(SYNC_STAGES)) u_smp (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .active(active), .cnt(cnt),
    .cur(cur), .rx_bit(rx_bit)
  );

  assign done = last;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done wide"); // R7

  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_en) |-> !done) else $error("done at start"); // R7

endmodule

// File: tb/sim_swd_host_bit.sv
module sim_swd_host_bit;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_rd = 1'b0, req_wbit = 1'b0;
  logic req_ready, drv_en, drv_hi, rx_bit, done;
  logic tgt_low = 1'b0;
  logic line_in;
  int total = 0, bad = 0;
  logic rx_exp = 1'b0;

  always #5 clk = ~clk;

  assign line_in = drv_en ? drv_hi : !tgt_low;

  swd_host_bit u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_rd(req_rd),
    .req_wbit(req_wbit), .req_ready(req_ready), .line_in(line_in),
    .drv_en(drv_en), .drv_hi(drv_hi), .rx_bit(rx_bit), .done(done)
  );

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Expected {drv_en, drv_hi} per slot cycle, written out per requirement.
  function automatic logic [1:0] exp_drive(logic rd, logic wbit, int k);
    if (rd)        return (k <= 1) ? 2'b10 : 2'b00;           // R5
    else if (wbit) return (k <= 3) ? 2'b10 : (k == 4) ? 2'b11 : 2'b00; // R3
    else           return (k <= 12) ? 2'b10 : (k == 13) ? 2'b11 : 2'b00; // R4
  endfunction

  task automatic issue(logic rd, logic wbit);
    @(negedge clk);
    req_valid = 1'b1; req_rd = rd; req_wbit = wbit;
  endtask

  // Watches one slot; the request was set before the accepting edge.
  task automatic watch_slot(logic rd, logic wbit, logic [15:0] tmask, logic keep,
                            logic nrd, logic nwbit, int poke);
    logic rx_new;
    string dtag;
    dtag = rd ? "R5" : (wbit ? "R3" : "R4");
    rx_new = !tmask[10];
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      tgt_low = tmask[k];
      chk(dtag, {2'b00, drv_en, drv_hi}, {2'b00, exp_drive(rd, wbit, k)});
      chk("R7", {3'b000, done}, {3'b000, (k == 15)});
      chk("R2", {3'b000, req_ready}, {3'b000, (k == 15)});
      if (k == 12 || (k == 13 && !rd)) chk("R6", {3'b000, rx_bit}, {3'b000, rx_exp});
      if (k == 13 && rd) begin
        rx_exp = rx_new;
        chk("R6", {3'b000, rx_bit}, {3'b000, rx_exp});
      end
      if (k == 0) begin
        if (keep) begin req_rd = nrd; req_wbit = nwbit; end
        else req_valid = 1'b0;
      end
      if (k == poke) begin req_valid = 1'b1; req_rd = 1'b1; req_wbit = 1'b1; end
      if (k == poke + 1) req_valid = 1'b0;
    end
    tgt_low = 1'b0;
  endtask

  task automatic check_idle(string tag);
    @(negedge clk);
    chk(tag, {1'b0, drv_en, done, req_ready}, 4'b0001);
    chk(tag, {3'b000, rx_bit}, {3'b000, rx_exp});
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1", {drv_en, drv_hi, done, rx_bit}, 4'b0000);
    chk("R1", {3'b000, req_ready}, 4'b0001);
  endtask

  task automatic t_write(logic wbit);
    issue(1'b0, wbit);
    watch_slot(1'b0, wbit, 16'h0000, 1'b0, 1'b0, 1'b0, -10);
    check_idle("R6");
  endtask

  task automatic t_read(logic [15:0] tmask);
    issue(1'b1, 1'b0);
    watch_slot(1'b1, 1'b0, tmask, 1'b0, 1'b0, 1'b0, -10);
    check_idle("R6");
  endtask

  task automatic t_back_to_back;
    issue(1'b0, 1'b1);
    watch_slot(1'b0, 1'b1, 16'h0000, 1'b1, 1'b1, 1'b0, -10);
    watch_slot(1'b1, 1'b0, 16'h0400, 1'b0, 1'b0, 1'b0, -10);
    check_idle("R2");
  endtask

  task automatic t_ignore_busy;
    issue(1'b0, 1'b0);
    watch_slot(1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 5);
    check_idle("R8");
    check_idle("R8");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_write(1'b1);
    t_write(1'b0);
    t_read(16'h0400);   // low only in cycle 10 -> 0
    t_write(1'b1);      // rx stays 0
    t_read(16'hFBFF);   // low everywhere but cycle 10 -> 1
    t_read(16'h0000);   // released -> 1
    t_read(16'h0780);   // low in cycles 7..10 -> 0
    t_back_to_back();
    t_ignore_busy();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule